// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block is the digital control for a divider that divides a fast input clock by an integer M = N·P + S. A dual-modulus prescaler outside the block divides the fast clock by N or N+1 and clocks this block once per prescaler output period. The block returns a modulus-select signal to the prescaler and produces a one-cycle output pulse once per divide period.

The block holds two loadable down counters. The program counter sets how many prescaler periods one output period lasts (P). The swallow counter keeps the prescaler in its N+1 mode for the first S of those periods. The output pulse is fed back as the shared reload, so both counters are preset again at the end of every period. The prescaler therefore swallows one extra input clock in each of the S high-modulus periods, and the total is (N+1)·S + N·(P−S) = N·P + S input clocks.

Settings are sampled only at a reload. A setting with P below 2, or with S not below P, is refused. The previous valid setting is kept and an error flag is raised for the period that follows.

Top module: `swallow_divider`

## Requirements
- R1: During and right after reset, `div_pulse` is 0, `mod_hi` is 1 and `cfg_err` is 0. The first period uses the default P=4, S=1, so the first pulse appears in the 4th prescaler cycle after reset is released.
- R2: With an accepted setting, `div_pulse` is high for exactly one prescaler cycle and recurs every P prescaler cycles.
- R3: `mod_hi` (1 selects divide by N+1, 0 selects divide by N) is high for exactly the first S cycles of each period and low for the rest. It is always low in the pulse cycle.
- R4: The fast input clocks per output period, summed as N+1 for each cycle with `mod_hi`=1 and N for each other cycle, equal N·P + S.
- R5: S = 0 is accepted. `mod_hi` then stays low for the whole period and the division is N·P.
- R6: A setting of P=8 (6'b001000) with S=0 produces one output pulse every 8 prescaler cycles.
- R7: Inputs changed in the middle of a period do not affect that period. They take effect from the next reload.
- R8: A setting with P below 2 is refused at reload. `cfg_err` becomes 1 for the next period, and that period repeats the last accepted P and S.
- R9: A setting with S greater than or equal to P is refused in the same way as R8.
- R10: An accepted setting clears `cfg_err` at its reload.
- R11: The largest setting, P=63 and S=62, gives a 63-cycle period with 62 high-modulus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_p | input | 6 | Program count P, sampled at reload |
| swal_s | input | 6 | Swallow count S, sampled at reload |
| mod_hi | output | 1 | Modulus select: 1 selects N+1, 0 selects N |
| div_pulse | output | 1 | One-cycle pulse at the end of each period |
| cfg_err | output | 1 | Last sampled setting was refused |

## Verification
The hardest situation to reach from the ports is a setting that changes in the middle of a period. It has to be shown to leave the running period untouched and to land exactly at the following reload, and a refused setting has to be shown to replay the previous ratio. The stimulus locks onto the output pulse, changes the inputs a cycle after a reload, and then measures two whole periods in turn. Random legal (P, S) pairs from a fixed seed are mixed with directed ones (S=0, P=8, the largest values, P=1, S=P). Each measured period is checked by bench functions that count the cycle length, the position of the high-modulus cycles and the fast-clock total.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;
  // A setting is usable when the swallow phase ends before the program count
  function automatic bit cfg_ok(input int unsigned p, input int unsigned s);
    return (p >= 2) && (s < p);
  endfunction

  // Fast input clocks in one output period
  function automatic int unsigned total_ratio(input int unsigned n,
                                              input int unsigned p,
                                              input int unsigned s);
    return n * p + s;
  endfunction
endpackage

// File: rtl/swallow_cfg_gate.sv
module swallow_cfg_gate
  import swallow_div_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int DEF_P = 4,
  parameter int DEF_S = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [CNT_W-1:0] p_in,
  input  logic [CNT_W-1:0] s_in,
  output logic [CNT_W-1:0] p_sel,
  output logic [CNT_W-1:0] s_sel,
  output logic             err
);
  logic [CNT_W-1:0] p_hold;
  logic [CNT_W-1:0] s_hold;
  logic             in_ok;

  assign in_ok = cfg_ok(int'(p_in), int'(s_in));
  assign p_sel = in_ok ? p_in : p_hold;
  assign s_sel = in_ok ? s_in : s_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_hold <= CNT_W'(DEF_P);
      s_hold <= CNT_W'(DEF_S);
      err    <= 1'b0;
    end else if (reload) begin
      p_hold <= p_sel;
      s_hold <= s_sel;
      err    <= !in_ok;
    end
  end

  // A refused setting leaves the held values untouched (R8, R9)
  assert_hold_on_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !in_ok) |=> ($stable(p_hold) && $stable(s_hold)));

  // The held setting is always a usable one
  assert_hold_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (p_hold >= CNT_W'(2)) && (s_hold < p_hold));
endmodule

// File: rtl/swallow_down_counter.sv
module swallow_down_counter #(
  parameter int W       = 6,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         zero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= W'(RST_VAL);
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);

  // Without a load the count steps down by one each cycle (R2)
  assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (cnt == $past(cnt) - W'(1)));

  // Without a load a count at zero stays at zero (R3)
  assert_rest_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swallow_div_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int DEF_P = 4,
  parameter int DEF_S = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] prog_p,
  input  logic [CNT_W-1:0] swal_s,
  output logic             mod_hi,
  output logic             div_pulse,
  output logic             cfg_err
);
  localparam int P_RST = DEF_P - 1;

  logic [CNT_W-1:0] p_sel;
  logic [CNT_W-1:0] s_sel;
  logic [CNT_W-1:0] p_cnt;
  logic [CNT_W-1:0] s_cnt;
  logic             p_zero;
  logic             s_zero;
  logic             reload;

  // End of a period: the output pulse is fed back as the shared load
  assign reload    = p_zero;
  assign div_pulse = p_zero;
  assign mod_hi    = !s_zero;

  swallow_cfg_gate #(.CNT_W(CNT_W), .DEF_P(DEF_P), .DEF_S(DEF_S)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (reload),
    .p_in   (prog_p),
    .s_in   (swal_s),
    .p_sel  (p_sel),
    .s_sel  (s_sel),
    .err    (cfg_err)
  );

  swallow_down_counter #(.W(CNT_W), .RST_VAL(P_RST)) u_prog (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (reload),
    .load_val (p_sel - CNT_W'(1)),
    .cnt      (p_cnt),
    .zero     (p_zero)
  );

  swallow_down_counter #(.W(CNT_W), .RST_VAL(DEF_S)) u_swal (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (reload),
    .load_val (s_sel),
    .cnt      (s_cnt),
    .zero     (s_zero)
  );

  // The pulse lasts a single cycle (R2)
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // The swallow phase is over before the program count expires (R3)
  assert_low_at_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> !mod_hi);

  // High modulus can only begin at a reload (R3)
  assert_rise_after_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_hi) |-> $past(div_pulse));

  // The error flag changes only at a reload (R10)
  assert_err_at_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !div_pulse |=> $stable(cfg_err));

  // The swallow count never exceeds the remaining program count (R9)
  assert_swallow_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s_cnt <= p_cnt + CNT_W'(1));
endmodule

// File: tb/swallow_divider_test.sv
module swallow_divider_test;
  localparam int N_PRE = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] prog_p = 6'd4;
  logic [5:0] swal_s = 6'd1;
  logic       mod_hi, div_pulse, cfg_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  swallow_divider uut (
    .clk(clk), .rst_n(rst_n), .prog_p(prog_p), .swal_s(swal_s),
    .mod_hi(mod_hi), .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  always #10 clk = ~clk;

  function automatic int unsigned exp_total(int unsigned p, int unsigned s);
    return (N_PRE + 1) * s + N_PRE * (p - s);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic sync_pulse();
    do @(negedge clk); while (!div_pulse);
  endtask

  // Measures the period after the current pulse; optionally changes inputs in cycle 1
  task automatic measure(output int len, output int highs, output int fast,
                         output bit order_bad, output bit err_seen,
                         input bit chg, input logic [5:0] np, input logic [5:0] ns);
    bit low_seen = 1'b0;
    len = 0; highs = 0; fast = 0; order_bad = 1'b0; err_seen = 1'b0;
    do begin
      @(negedge clk);
      len++;
      if (len == 1) begin
        err_seen = cfg_err;
        if (chg) begin prog_p = np; swal_s = ns; end
      end
      if (mod_hi) begin
        highs++; fast += N_PRE + 1;
        if (low_seen) order_bad = 1'b1;
      end else begin
        low_seen = 1'b1; fast += N_PRE;
      end
    end while (!div_pulse && len < 200);
  endtask

  task automatic run_case(input string req, input int p, input int s,
                          input bit exp_err, input int ep, input int es);
    int len, highs, fast; bit ob, es_seen;
    prog_p = 6'(p); swal_s = 6'(s);
    sync_pulse();
    measure(len, highs, fast, ob, es_seen, 1'b0, 6'd0, 6'd0);
    check(len == ep, req, "period", len, ep);
    check(highs == es, req, "high cycles", highs, es);
    check(!ob, req, "high cycles not leading", int'(ob), 0);
    check(fast == int'(exp_total(ep, es)), req, "fast clocks", fast,
          int'(exp_total(ep, es)));
    check(es_seen == exp_err, req, "cfg_err", int'(es_seen), int'(exp_err));
  endtask

  initial begin
    int len, highs, fast; bit ob, es_seen;
    int rp, rs;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state and first default period
    check(div_pulse == 1'b0, "R1", "div_pulse after reset", int'(div_pulse), 0);
    check(mod_hi == 1'b1, "R1", "mod_hi after reset", int'(mod_hi), 1);
    check(cfg_err == 1'b0, "R1", "cfg_err after reset", int'(cfg_err), 0);
    len = 1;
    while (!div_pulse && len < 50) begin @(negedge clk); len++; end
    check(len == 4, "R1", "first period", len, 4);

    run_case("R2", 5, 2, 1'b0, 5, 2);
    run_case("R4", 10, 3, 1'b0, 10, 3);
    run_case("R5", 7, 0, 1'b0, 7, 0);
    run_case("R6", 8, 0, 1'b0, 8, 0);
    run_case("R11", 63, 62, 1'b0, 63, 62);
    run_case("R3", 2, 1, 1'b0, 2, 1);

    // R7: change in cycle 1 of a period; that period keeps the old setting
    prog_p = 6'd9; swal_s = 6'd4;
    sync_pulse();
    measure(len, highs, fast, ob, es_seen, 1'b1, 6'd12, 6'd5);
    check(len == 9, "R7", "period before change lands", len, 9);
    check(highs == 4, "R7", "highs before change lands", highs, 4);
    measure(len, highs, fast, ob, es_seen, 1'b0, 6'd0, 6'd0);
    check(len == 12, "R7", "period after change", len, 12);
    check(highs == 5, "R7", "highs after change", highs, 5);

    // R8, R9: refused settings replay last accepted (12,5)
    run_case("R8", 1, 0, 1'b1, 12, 5);
    run_case("R9", 6, 6, 1'b1, 12, 5);
    run_case("R9", 0, 0, 1'b1, 12, 5);
    // R10: accepted setting clears the flag
    run_case("R10", 3, 2, 1'b0, 3, 2);

    // Random legal settings
    for (int i = 0; i < 20; i++) begin
      rp = 2 + int'($urandom_range(61));
      rs = int'($urandom_range(rp - 1));
      run_case("R4", rp, rs, 1'b0, rp, rs);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule